// File: doc/BRIEF.md
# Segmented Data Memory Address Unit

This unit sits between the execute stage of a small 8-bit controller core and its data RAM. Each cycle it takes one data access request: an operation, an addressing mode, a post-adjust choice, an 8-bit address, a bit index and a write byte. It forms the effective address either from the instruction (direct) or from one of two internal data pointers (indirect). It then turns that address into a physical RAM address and performs the access. The access can be a read, a write, a single-bit set, clear or test, or a decrement that raises a skip flag when the result is zero.

The lower half of the 8-bit address space is stretched by an 8-bit bank register into 256 banks of 128 bytes. The upper half maps to one fixed physical window, whatever the bank register holds. The top sixteen addresses of the space are not sent to RAM. They form a register bank held inside the unit. Three of these slots are the first data pointer, the stack pointer and the second data pointer, and the last slot is reserved. The RAM array sits outside the unit and must return read data combinationally for the address the unit presents. Read-modify-write operations then finish in one cycle.

Top module: `segmem_xlate`

## Requirements
- R1: For an effective address 0x00 to 0x7F the physical address is {1'b0, bank, addr[6:0]}. The bank register loads from the write byte when op = 7 (bank load), and the new bank applies from the next cycle.
- R2: For an effective address 0x80 to 0xFF the physical address is {1'b1, 8'h00, addr[6:0]} whatever the bank register holds.
- R3: Mode 0 uses the instruction address, mode 1 the first pointer (slot 0xFC) and mode 2 the second pointer (slot 0xFE). In an indirect access with post = 1 the pointer increments, and with post = 2 it decrements, modulo 256, from the next cycle on. The adjustment wins over a data write to that same pointer slot.
- R4: Addresses 0xF0 to 0xFE are internal registers. A write (op = 2) loads the given byte, a read returns it, and mem_we stays low. 0xFC is the first pointer, 0xFD the stack pointer and 0xFE the second pointer.
- R5: After reset the stack pointer reads 0x6F when RAM_BYTES is 128 and 0x2F when RAM_BYTES is 64. The other register slots and the bank register are 0x00.
- R6: A read of the reserved address 0xFF returns 0x00, and writes to it change nothing.
- R7: Bit set (op = 3) and bit clear (op = 4) change only bit bit_i of the target byte. This holds both for RAM (through mem_wdata) and for the register slots.
- R8: Bit test (op = 5) returns {7'b0, selected bit} on rd_data and writes nothing.
- R9: Decrement-and-skip (op = 6) on 0xF0 to 0xFE stores the byte minus one and raises skip in that cycle if and only if the result is zero. On any other address it writes nothing and skip stays low.
- R10: Read (op = 1) of an address 0x00 to 0xEF returns mem_rdata. Write, bit set and bit clear to such an address raise mem_we with the new byte on mem_wdata. Op 0 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation: 0 idle, 1 read, 2 write, 3 bit set, 4 bit clear, 5 bit test, 6 decrement-and-skip, 7 bank load |
| mode_i | input | 2 | Addressing: 0 direct, 1 first pointer, 2 second pointer |
| post_i | input | 2 | Pointer post-adjust: 0 none, 1 increment, 2 decrement |
| addr_i | input | 8 | Direct address from the instruction |
| bit_i | input | 3 | Bit index for bit operations |
| wdata_i | input | 8 | Write byte, or new bank for op 7 |
| mem_rdata_i | input | 8 | Combinational read data from the external RAM |
| phys_addr_o | output | 16 | Physical address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_wdata_o | output | 8 | RAM write byte |
| rd_data_o | output | 8 | Read result |
| skip_o | output | 1 | Skip request from decrement-and-skip |

## Verification
The hardest case to reach from the ports is an indirect access whose own pointer points at its own slot. There the data write and the post-adjust both target the same register in the same cycle. The stimulus first loads the second pointer with the value 0xFE through a direct write. It then writes through that pointer with post-increment, and reads the slot back both directly and through the pointer. Pointer wrap is reached the same way: the stimulus preloads 0xFF or 0x00 into a pointer slot and then accesses through it with the adjust that crosses the boundary.

// File: rtl/smx_pkg.sv
package smx_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_BSET = 3'd3,
    OP_BCLR = 3'd4,
    OP_BTST = 3'd5,
    OP_DSZ  = 3'd6,
    OP_BANK = 3'd7
  } smx_op_e;

  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_PTR_A  = 2'd1,
    AM_PTR_B  = 2'd2,
    AM_SPARE  = 2'd3
  } smx_mode_e;

  typedef enum logic [1:0] {
    PA_NONE  = 2'd0,
    PA_INC   = 2'd1,
    PA_DEC   = 2'd2,
    PA_SPARE = 2'd3
  } smx_post_e;

endpackage

// File: rtl/smx_seg_map.sv
module smx_seg_map #(
  parameter int unsigned W     = 8,
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_we,
  input  logic [W-1:0]     seg_wdata,
  input  logic [W-1:0]     eff_addr,
  output logic [W+SEG_W-1:0] phys_addr
);
  localparam int unsigned OFF_W = W - 1;

  logic [SEG_W-1:0] seg_q, seg_d;

  always_comb begin
    seg_d = seg_q;
    if (seg_we) seg_d = SEG_W'(seg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seg_q <= '0;
    else if (seg_we) seg_q <= seg_d;
  end

  always_comb begin
    if (eff_addr[W-1]) phys_addr = {1'b1, {SEG_W{1'b0}}, eff_addr[OFF_W-1:0]};
    else               phys_addr = {1'b0, seg_q, eff_addr[OFF_W-1:0]};
  end

  assert_bank_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_we |=> seg_q == $past(SEG_W'(seg_wdata)));

endmodule

// File: rtl/smx_reg_bank.sv
module smx_reg_bank #(
  parameter int unsigned W         = 8,
  parameter int unsigned BANK_N    = 16,
  parameter int unsigned RAM_BYTES = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(BANK_N)-1:0] rd_idx,
  output logic [W-1:0]              rd_data,
  input  logic                      wr_en,
  input  logic [$clog2(BANK_N)-1:0] wr_idx,
  input  logic [W-1:0]              wr_data,
  input  logic                      adj_en,
  input  logic [$clog2(BANK_N)-1:0] adj_idx,
  input  logic                      adj_dec,
  output logic [W-1:0]              ptr_a,
  output logic [W-1:0]              ptr_b
);
  localparam int unsigned BW      = $clog2(BANK_N);
  localparam int unsigned NREG    = BANK_N - 1;
  localparam int unsigned A_IDX   = BANK_N - 4;
  localparam int unsigned SP_IDX  = BANK_N - 3;
  localparam int unsigned B_IDX   = BANK_N - 2;
  localparam logic [W-1:0] SP_INIT = (RAM_BYTES >= 128) ? W'(8'h6F) : W'(8'h2F);

  logic [W-1:0] rf_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gen_slot
    logic         hit_w, hit_a, en;
    logic [W-1:0] nxt;

    always_comb begin
      hit_w = wr_en  && (wr_idx  == BW'(g));
      hit_a = adj_en && (adj_idx == BW'(g));
      en    = hit_w || hit_a;
      if (hit_a) nxt = adj_dec ? rf_q[g] - W'(1) : rf_q[g] + W'(1);
      else       nxt = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rf_q[g] <= (g == SP_IDX) ? SP_INIT : '0;
      else if (en) rf_q[g] <= nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == BW'(i)) rd_data = rf_q[i];
    end
  end

  assign ptr_a = rf_q[A_IDX];
  assign ptr_b = rf_q[B_IDX];

  assert_ptr_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && !adj_dec && adj_idx == BW'(A_IDX)) |=> ptr_a == $past(ptr_a) + W'(1));

  assert_ptr_dec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_en && adj_dec && adj_idx == BW'(B_IDX)) |=> ptr_b == $past(ptr_b) - W'(1));

endmodule

// File: rtl/smx_byte_op.sv
module smx_byte_op
  import smx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  smx_op_e              op,
  input  logic [W-1:0]         old_byte,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(W)-1:0] bit_sel,
  output logic [W-1:0]         new_byte,
  output logic                 test_bit
);
  logic [W-1:0] mask;

  assign mask     = W'(1) << bit_sel;
  assign test_bit = old_byte[bit_sel];

  always_comb begin
    case (op)
      OP_WR:   new_byte = wdata;
      OP_BSET: new_byte = old_byte | mask;
      OP_BCLR: new_byte = old_byte & ~mask;
      OP_DSZ:  new_byte = old_byte - W'(1);
      default: new_byte = old_byte;
    endcase
  end

  always_comb begin
    if (op == OP_BSET) begin
      assert_bset_one_bit_R7: assert (new_byte[bit_sel] && $countones(new_byte ^ old_byte) <= 1);
    end
    if (op == OP_BCLR) begin
      assert_bclr_one_bit_R7: assert (!new_byte[bit_sel] && $countones(new_byte ^ old_byte) <= 1);
    end
  end

endmodule

// File: rtl/segmem_xlate.sv
module segmem_xlate
  import smx_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned SEG_W     = 8,
  parameter int unsigned BANK_N    = 16,
  parameter int unsigned RAM_BYTES = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op_i,
  input  logic [1:0]           mode_i,
  input  logic [1:0]           post_i,
  input  logic [W-1:0]         addr_i,
  input  logic [$clog2(W)-1:0] bit_i,
  input  logic [W-1:0]         wdata_i,
  input  logic [W-1:0]         mem_rdata_i,
  output logic [W+SEG_W-1:0]   phys_addr_o,
  output logic                 mem_we_o,
  output logic [W-1:0]         mem_wdata_o,
  output logic [W-1:0]         rd_data_o,
  output logic                 skip_o
);
  localparam int unsigned BW        = $clog2(BANK_N);
  localparam int unsigned BANK_BASE = (1 << W) - BANK_N;
  localparam int unsigned A_IDX     = BANK_N - 4;
  localparam int unsigned B_IDX     = BANK_N - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  smx_op_e   op;
  smx_mode_e mode;
  smx_post_e post;
  assign op   = smx_op_e'(op_i);
  assign mode = smx_mode_e'(mode_i);
  assign post = smx_post_e'(post_i);

  logic [W-1:0] ptr_a, ptr_b, eff, bank_rd, old_byte, new_byte;
  logic         in_bank, rsvd, test_bit, modifies, bank_we, adj_en, indirect;

  always_comb begin
    case (mode)
      AM_PTR_A: eff = ptr_a;
      AM_PTR_B: eff = ptr_b;
      default:  eff = addr_i;
    endcase
  end

  assign in_bank  = eff >= W'(BANK_BASE);
  assign rsvd     = &eff;
  assign old_byte = in_bank ? bank_rd : mem_rdata_i;

  assign modifies = (op == OP_WR) || (op == OP_BSET) || (op == OP_BCLR) ||
                    ((op == OP_DSZ) && in_bank);
  assign bank_we  = modifies && in_bank && !rsvd;
  assign indirect = (mode == AM_PTR_A) || (mode == AM_PTR_B);
  assign adj_en   = indirect && ((post == PA_INC) || (post == PA_DEC)) &&
                    (op != OP_IDLE) && (op != OP_BANK);

  always_comb begin
    mem_we_o    = modifies && !in_bank;
    mem_wdata_o = new_byte;
    skip_o      = (op == OP_DSZ) && in_bank && !rsvd && (new_byte == '0);
    case (op)
      OP_RD:   rd_data_o = old_byte;
      OP_BTST: rd_data_o = {{(W-1){1'b0}}, test_bit};
      default: rd_data_o = '0;
    endcase
  end

  smx_seg_map #(.W(W), .SEG_W(SEG_W)) seg_i (
    .clk       (clk),
    .rst_n     (rst_s),
    .seg_we    (op == OP_BANK),
    .seg_wdata (wdata_i),
    .eff_addr  (eff),
    .phys_addr (phys_addr_o)
  );

  smx_reg_bank #(.W(W), .BANK_N(BANK_N), .RAM_BYTES(RAM_BYTES)) bank_i (
    .clk     (clk),
    .rst_n   (rst_s),
    .rd_idx  (eff[BW-1:0]),
    .rd_data (bank_rd),
    .wr_en   (bank_we),
    .wr_idx  (eff[BW-1:0]),
    .wr_data (new_byte),
    .adj_en  (adj_en),
    .adj_idx ((mode == AM_PTR_A) ? BW'(A_IDX) : BW'(B_IDX)),
    .adj_dec (post == PA_DEC),
    .ptr_a   (ptr_a),
    .ptr_b   (ptr_b)
  );

  smx_byte_op #(.W(W)) alu_i (
    .op       (op),
    .old_byte (old_byte),
    .wdata    (wdata_i),
    .bit_sel  (bit_i),
    .new_byte (new_byte),
    .test_bit (test_bit)
  );

  assert_high_no_bank_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(op_i) == 3'd7 && eff[W-1] && eff == $past(eff)) |-> phys_addr_o == $past(phys_addr_o));

  assert_bank_no_ram_we_R4: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we_o |-> !(phys_addr_o[W+SEG_W-1] && (phys_addr_o[W-2:BW] == '1)));

  assert_rsvd_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (op_i == 3'd1 && eff == '1) |-> rd_data_o == '0);

  assert_btst_no_write_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (op_i == 3'd5) |-> !mem_we_o);

  assert_skip_only_dsz_R9: assert property (@(posedge clk) disable iff (!rst_s)
    skip_o |-> (op_i == 3'd6));

endmodule

// File: tb/segmem_xlate_tb_top.sv
module segmem_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [1:0]  mode_i, post_i;
  logic [7:0]  addr_i, wdata_i, mem_rdata_i;
  logic [2:0]  bit_i;
  logic [15:0] phys_addr_o, phys64;
  logic        mem_we_o, skip_o, we64, skip64;
  logic [7:0]  mem_wdata_o, rd_data_o, wd64, rd64;

  always #10 clk = ~clk;  // 50 MHz

  segmem_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_i(mode_i), .post_i(post_i),
    .addr_i(addr_i), .bit_i(bit_i), .wdata_i(wdata_i), .mem_rdata_i(mem_rdata_i),
    .phys_addr_o(phys_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .rd_data_o(rd_data_o), .skip_o(skip_o));

  segmem_xlate #(.RAM_BYTES(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_i(mode_i), .post_i(post_i),
    .addr_i(addr_i), .bit_i(bit_i), .wdata_i(wdata_i), .mem_rdata_i(mem_rdata_i),
    .phys_addr_o(phys64), .mem_we_o(we64), .mem_wdata_o(wd64),
    .rd_data_o(rd64), .skip_o(skip64));

  typedef struct {
    logic [15:0] phys;
    logic        we;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic        skip;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  // reference model state
  logic [7:0] m_rf [15];
  logic [7:0] m_seg;
  logic [7:0] m_ram [logic [15:0]];

  function automatic logic [7:0] ram_get(logic [15:0] p);
    if (m_ram.exists(p)) return m_ram[p];
    return 8'h00;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [1:0] md, input logic [1:0] pst,
                       input logic [7:0] a, input logic [2:0] bn, input logic [7:0] wd,
                       input string tag);
    logic [7:0]  eff, old, nb, pv;
    logic [15:0] phys;
    logic        bank, rs, wr;
    int          pidx;
    exp_t        e;
    @(negedge clk);
    pidx = (md == 2'd1) ? 12 : 14;
    pv   = m_rf[pidx];
    eff  = (md == 2'd1) ? m_rf[12] : (md == 2'd2) ? m_rf[14] : a;
    phys = eff[7] ? {1'b1, 8'h00, eff[6:0]} : {1'b0, m_seg, eff[6:0]};
    bank = eff >= 8'hF0;
    rs   = eff == 8'hFF;
    old  = bank ? (rs ? 8'h00 : m_rf[eff[3:0]]) : ram_get(phys);
    case (op)
      3'd2: nb = wd;
      3'd3: nb = old | (8'h01 << bn);
      3'd4: nb = old & ~(8'h01 << bn);
      3'd6: nb = old - 8'h01;
      default: nb = old;
    endcase
    wr     = (op == 3'd2) || (op == 3'd3) || (op == 3'd4) || (op == 3'd6 && bank);
    e.phys = phys;
    e.we   = wr && !bank;
    e.wd   = nb;
    e.rd   = (op == 3'd1) ? old : (op == 3'd5) ? {7'b0, old[bn]} : 8'h00;
    e.skip = (op == 3'd6) && bank && !rs && (nb == 8'h00);
    e.tag  = tag;
    op_i = op; mode_i = md; post_i = pst; addr_i = a; bit_i = bn; wdata_i = wd;
    mem_rdata_i = ram_get(phys);
    if (e.we) m_ram[phys] = nb;
    if (wr && bank && !rs) m_rf[eff[3:0]] = nb;
    if (op == 3'd7) m_seg = wd;
    if ((md == 2'd1 || md == 2'd2) && (pst == 2'd1 || pst == 2'd2) && op != 3'd0 && op != 3'd7)
      m_rf[pidx] = (pst == 2'd1) ? pv + 8'h01 : pv - 8'h01;
    q.push_back(e);
  endtask

  // monitor: compare each expected item a quarter period after it is driven
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (phys_addr_o !== e.phys || mem_we_o !== e.we || (e.we && mem_wdata_o !== e.wd) ||
            rd_data_o !== e.rd || skip_o !== e.skip) begin
          bad++;
          $display("FAIL %s: phys=%h/%h we=%b/%b wd=%h/%h rd=%h/%h skip=%b/%b (actual/expected)",
                   e.tag, phys_addr_o, e.phys, mem_we_o, e.we, mem_wdata_o, e.wd,
                   rd_data_o, e.rd, skip_o, e.skip);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) m_rf[i] = 8'h00;
    m_rf[13] = 8'h6F;
    m_seg = 8'h00;
    rst_n = 1'b0;
    op_i = 3'd0; mode_i = 2'd0; post_i = 2'd0; addr_i = 8'h00;
    bit_i = 3'd0; wdata_i = 8'h00; mem_rdata_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: reset values
    issue(3'd1, 2'd0, 2'd0, 8'hFD, 3'd0, 8'h00, "R5 stack pointer reset");
    #5;
    total++;
    if (rd64 !== 8'h2F) begin
      bad++;
      $display("FAIL R5 small-RAM stack pointer: actual=%h expected=%h", rd64, 8'h2F);
    end
    issue(3'd1, 2'd0, 2'd0, 8'hFC, 3'd0, 8'h00, "R5 first pointer reset");
    issue(3'd1, 2'd0, 2'd0, 8'hFE, 3'd0, 8'h00, "R5 second pointer reset");
    issue(3'd1, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h00, "R5 register slot reset");

    // R10 / R1: RAM access and bank mapping
    issue(3'd2, 2'd0, 2'd0, 8'h10, 3'd0, 8'hA5, "R10 RAM write bank 0");
    issue(3'd1, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R10 RAM read bank 0");
    issue(3'd7, 2'd0, 2'd0, 8'h00, 3'd0, 8'h03, "R1 bank load 3");
    issue(3'd2, 2'd0, 2'd0, 8'h10, 3'd0, 8'h5A, "R1 write in bank 3");
    issue(3'd1, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R1 read in bank 3");
    issue(3'd2, 2'd0, 2'd0, 8'h90, 3'd0, 8'hC3, "R2 upper write bank 3");
    issue(3'd7, 2'd0, 2'd0, 8'h00, 3'd0, 8'h00, "R1 bank load 0");
    issue(3'd1, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R1 read in bank 0");
    issue(3'd1, 2'd0, 2'd0, 8'h90, 3'd0, 8'h00, "R2 upper read bank 0");
    issue(3'd7, 2'd0, 2'd0, 8'h00, 3'd0, 8'hFF, "R1 bank load FF");
    issue(3'd1, 2'd0, 2'd0, 8'h7F, 3'd0, 8'h00, "R1 top of low half bank FF");
    issue(3'd1, 2'd0, 2'd0, 8'h80, 3'd0, 8'h00, "R2 bottom of upper half");
    issue(3'd7, 2'd0, 2'd0, 8'h00, 3'd0, 8'h00, "R1 bank load 0 again");

    // R4 / R9: register slots and decrement-and-skip
    issue(3'd2, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h02, "R4 immediate load slot F0");
    issue(3'd1, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h00, "R4 read slot F0");
    issue(3'd6, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h00, "R9 decrement to 1 no skip");
    issue(3'd6, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h00, "R9 decrement to 0 skip");
    issue(3'd6, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h00, "R9 decrement wraps to FF");
    issue(3'd1, 2'd0, 2'd0, 8'hF0, 3'd0, 8'h00, "R9 slot after wrap");
    issue(3'd6, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R9 decrement on RAM ignored");
    issue(3'd1, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R9 RAM byte unchanged");
    issue(3'd6, 2'd0, 2'd0, 8'hFF, 3'd0, 8'h00, "R9 decrement on reserved");

    // R3: indirect access and post-adjust
    issue(3'd2, 2'd0, 2'd0, 8'hFC, 3'd0, 8'h20, "R4 load first pointer");
    issue(3'd2, 2'd1, 2'd1, 8'h00, 3'd0, 8'h11, "R3 write via first pointer inc");
    issue(3'd2, 2'd1, 2'd0, 8'h00, 3'd0, 8'h22, "R3 write via first pointer after inc");
    issue(3'd1, 2'd1, 2'd2, 8'h00, 3'd0, 8'h00, "R3 read via first pointer dec");
    issue(3'd1, 2'd1, 2'd0, 8'h00, 3'd0, 8'h00, "R3 read via first pointer after dec");
    issue(3'd1, 2'd0, 2'd0, 8'hFC, 3'd0, 8'h00, "R3 first pointer value");
    issue(3'd2, 2'd0, 2'd0, 8'hFC, 3'd0, 8'hFF, "R3 first pointer to FF");
    issue(3'd1, 2'd1, 2'd1, 8'h00, 3'd0, 8'h00, "R3 inc wraps FF to 00");
    issue(3'd1, 2'd0, 2'd0, 8'hFC, 3'd0, 8'h00, "R3 first pointer wrapped");
    issue(3'd1, 2'd2, 2'd2, 8'h00, 3'd0, 8'h00, "R3 dec wraps 00 to FF");
    issue(3'd1, 2'd0, 2'd0, 8'hFE, 3'd0, 8'h00, "R3 second pointer wrapped");
    issue(3'd2, 2'd0, 2'd0, 8'hFE, 3'd0, 8'hFE, "R3 second pointer at own slot");
    issue(3'd2, 2'd2, 2'd1, 8'h00, 3'd0, 8'h33, "R3 write own slot with inc");
    issue(3'd1, 2'd0, 2'd0, 8'hFE, 3'd0, 8'h00, "R3 adjust wins over write");
    issue(3'd1, 2'd2, 2'd0, 8'h00, 3'd0, 8'h00, "R6 read reserved via pointer");

    // R6: reserved slot
    issue(3'd2, 2'd0, 2'd0, 8'hFF, 3'd0, 8'h77, "R6 write reserved");
    issue(3'd1, 2'd0, 2'd0, 8'hFF, 3'd0, 8'h00, "R6 read reserved");

    // R7 / R8: bit operations
    issue(3'd3, 2'd0, 2'd0, 8'h10, 3'd3, 8'h00, "R7 set bit 3 in RAM");
    issue(3'd4, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R7 clear bit 0 in RAM");
    issue(3'd1, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R7 RAM byte after bit ops");
    issue(3'd2, 2'd0, 2'd0, 8'hF1, 3'd0, 8'h81, "R4 load slot F1");
    issue(3'd3, 2'd0, 2'd0, 8'hF1, 3'd4, 8'h00, "R7 set bit 4 in slot");
    issue(3'd4, 2'd0, 2'd0, 8'hF1, 3'd7, 8'h00, "R7 clear bit 7 in slot");
    issue(3'd1, 2'd0, 2'd0, 8'hF1, 3'd0, 8'h00, "R7 slot after bit ops");
    issue(3'd5, 2'd0, 2'd0, 8'h10, 3'd7, 8'h00, "R8 test bit 7 set");
    issue(3'd5, 2'd0, 2'd0, 8'h10, 3'd6, 8'h00, "R8 test bit 6 clear");
    issue(3'd5, 2'd0, 2'd0, 8'hF1, 3'd4, 8'h00, "R8 test bit in slot");
    issue(3'd0, 2'd0, 2'd0, 8'h10, 3'd0, 8'h00, "R10 idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule